// File: doc/BRIEF.md
# Register File with Busy-Bit Issue Interlock

This block is the operand store of a simple in-order integer pipeline together with the decode-stage interlock that guards it. It holds 32 data words and one busy flag per word. Decode presents an instruction's two source indices, its destination index and a flag saying whether it writes a destination. The block answers in the same cycle with both operand values and a stall decision. A source whose busy flag is set is a read-after-write hazard. A destination whose busy flag is set is a write-after-write hazard. Either hazard holds the instruction in decode.

When the instruction issues without a stall and names a destination, that destination's busy flag is set at the next clock. The write-back port later stores the result and clears the flag. A write-back is forwarded to the read ports and to the hazard check in the cycle it arrives, so a waiting instruction can issue in the same cycle its operand lands. Entry 0 always reads as zero and can never become busy. Decode ties an unused source index to 0 so that it never stalls.

Top module: `regscb_top`

## Requirements
- R1: After a synchronous active-high reset every entry reads zero and no busy flag is set, so no request stalls.
- R2: Entry 0 always reads zero on both read ports. Write-backs to index 0 are ignored, and an issue with destination 0 sets no busy flag.
- R3: When `req_valid` is high, `stall` is low, `req_has_dst` is high and `req_dst` is nonzero, the busy flag of `req_dst` is set at the next clock edge.
- R4: When `wb_en` is high and `wb_idx` is nonzero, `wb_data` is stored in entry `wb_idx` at the clock edge and its busy flag is cleared.
- R5: With `req_valid` high, a busy flag on `req_src_a` or `req_src_b` drives `raw_hazard` and `stall` high in the same cycle.
- R6: With `req_valid` and `req_has_dst` high, a busy flag on `req_dst` drives `waw_hazard` and `stall` high in the same cycle. The destination is not checked when `req_has_dst` is low.
- R7: A stalled request changes no busy flag. The check is repeated every cycle against the current flags, so the request issues in the first cycle no hazard remains.
- R8: A write-back in a cycle is visible in that cycle: `rd_data_a` and `rd_data_b` return `wb_data` for a matching nonzero index, and that register counts as not busy for both hazard checks.
- R9: When an issue sets and a write-back clears the same register in one cycle, the register is busy afterwards and holds `wb_data`.
- R10: `stall`, `raw_hazard` and `waw_hazard` are low whenever `req_valid` is low. The two read ports return their own indices independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Decode holds an instruction to check |
| req_src_a | input | 5 | First source index |
| req_src_b | input | 5 | Second source index |
| req_dst | input | 5 | Destination index |
| req_has_dst | input | 1 | Instruction writes a destination |
| rd_data_a | output | 32 | Value of first source, with write-back forwarding |
| rd_data_b | output | 32 | Value of second source, with write-back forwarding |
| raw_hazard | output | 1 | A source register is busy |
| waw_hazard | output | 1 | The destination register is busy |
| stall | output | 1 | Instruction must wait in decode |
| wb_en | input | 1 | Write-back strobe |
| wb_idx | input | 5 | Write-back register index |
| wb_data | input | 32 | Write-back value |

## Verification
Issue and write-back can fall in the same cycle. They meet in two ways. A write-back can release the hazard that is holding the current request, so the request must issue in that very cycle. A write-back can also clear the same register that the issuing instruction claims, so the set must win. Directed sequences provoke both cases. Random traffic on a small window of register indices makes them frequent. A bench model, updated at each clock with clear before set, judges every cycle's stall, hazard and operand outputs and then the flag state visible through later requests.

// File: rtl/regscb_pkg.sv
package regscb_pkg;

    localparam int NUM_REGS = 32;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef logic [IDX_W-1:0]  ridx_t;
    typedef logic [DATA_W-1:0] word_t;

    // Decode-side request.
    typedef struct packed {
        logic  valid;
        ridx_t src_a;
        ridx_t src_b;
        ridx_t dst;
        logic  has_dst;
    } dec_req_t;

    // Write-back request.
    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } wb_req_t;

    // One-hot select with entry 0 masked out (entry 0 is never written or claimed).
    function automatic logic [NUM_REGS-1:0] sel_nonzero(input logic fire, input ridx_t idx);
        logic [NUM_REGS-1:0] v;
        v = '0;
        if (fire && idx != '0) v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/regscb_store.sv
module regscb_store
    import regscb_pkg::*;
#(
    parameter int N  = NUM_REGS,
    parameter int DW = DATA_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  wr_oh,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx_a,
    input  logic [IW-1:0] rd_idx_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);

    logic [N-1:0][DW-1:0] mem_q;
    logic                 wr_any;

    assign wr_any = |wr_oh;

    for (genvar i = 0; i < N; i++) begin : g_ent
        if (i == 0) begin : g_zero
            assign mem_q[i] = '0;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)           mem_q[i] <= '0;
                else if (wr_oh[i]) mem_q[i] <= wr_data;
            end
        end
    end

    // Write-before-read: a same-cycle write is forwarded to the readers.
    always_comb begin
        rd_a = mem_q[rd_idx_a];
        rd_b = mem_q[rd_idx_b];
        if (wr_any && wr_idx == rd_idx_a) rd_a = wr_data;
        if (wr_any && wr_idx == rd_idx_b) rd_b = wr_data;
    end

endmodule

// File: rtl/regscb_busy.sv
module regscb_busy
    import regscb_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_oh,
    input  logic [N-1:0] clr_oh,
    output logic [N-1:0] busy_q,
    output logic [N-1:0] busy_eff
);

    // View seen by the hazard check: flags being cleared this cycle are free.
    assign busy_eff = busy_q & ~clr_oh;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == 0) begin : g_zero
            assign busy_q[i] = 1'b0;
        end else begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)            busy_q[i] <= 1'b0;
                else if (set_oh[i]) busy_q[i] <= 1'b1;   // set wins over clear
                else if (clr_oh[i]) busy_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/regscb_hazard.sv
module regscb_hazard
    import regscb_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  dec_req_t     req,
    input  logic [N-1:0] busy_eff,
    output logic         raw,
    output logic         waw,
    output logic         stall
);

    always_comb begin
        raw   = req.valid && (busy_eff[req.src_a] || busy_eff[req.src_b]);
        waw   = req.valid && req.has_dst && busy_eff[req.dst];
        stall = raw || waw;
    end

endmodule

// File: rtl/regscb_top.sv
module regscb_top
    import regscb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_src_a,
    input  logic [IDX_W-1:0]  req_src_b,
    input  logic [IDX_W-1:0]  req_dst,
    input  logic              req_has_dst,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              raw_hazard,
    output logic              waw_hazard,
    output logic              stall,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data
);

    dec_req_t            req;
    wb_req_t             wb;
    logic [NUM_REGS-1:0] set_oh;
    logic [NUM_REGS-1:0] clr_oh;
    logic [NUM_REGS-1:0] busy_q;
    logic [NUM_REGS-1:0] busy_eff;
    logic                issue;

    assign req = '{valid: req_valid, src_a: req_src_a, src_b: req_src_b,
                   dst: req_dst, has_dst: req_has_dst};
    assign wb  = '{en: wb_en, idx: wb_idx, data: wb_data};

    assign issue  = req.valid && !stall && req.has_dst;
    assign set_oh = sel_nonzero(issue, req.dst);
    assign clr_oh = sel_nonzero(wb.en, wb.idx);

    regscb_store #(.N(NUM_REGS), .DW(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_oh    (clr_oh),
        .wr_idx   (wb.idx),
        .wr_data  (wb.data),
        .rd_idx_a (req.src_a),
        .rd_idx_b (req.src_b),
        .rd_a     (rd_data_a),
        .rd_b     (rd_data_b)
    );

    regscb_busy #(.N(NUM_REGS)) u_busy (
        .clk      (clk),
        .rst      (rst),
        .set_oh   (set_oh),
        .clr_oh   (clr_oh),
        .busy_q   (busy_q),
        .busy_eff (busy_eff)
    );

    regscb_hazard #(.N(NUM_REGS)) u_haz (
        .req      (req),
        .busy_eff (busy_eff),
        .raw      (raw_hazard),
        .waw      (waw_hazard),
        .stall    (stall)
    );

endmodule

// File: rtl/regscb_checker.sv
module regscb_checker
    import regscb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [IDX_W-1:0]    req_src_a,
    input logic [IDX_W-1:0]    req_dst,
    input logic                req_has_dst,
    input logic [DATA_W-1:0]   rd_data_a,
    input logic                stall,
    input logic                wb_en,
    input logic [IDX_W-1:0]    wb_idx,
    input logic [NUM_REGS-1:0] busy_q
);

    logic issue_seen;
    assign issue_seen = req_valid && !stall && req_has_dst && req_dst != '0;

    assert_zero_never_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !busy_q[0]);

    assert_zero_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req_src_a == '0) |-> (rd_data_a == '0));

    assert_issue_sets_R3: assert property (@(posedge clk) disable iff (rst)
        issue_seen |=> busy_q[$past(req_dst)]);

    assert_wb_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_idx != '0 && !(issue_seen && req_dst == wb_idx))
        |=> !busy_q[$past(wb_idx)]);

    assert_stall_holds_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (stall && !wb_en) |=> $stable(busy_q));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (issue_seen && wb_en && wb_idx == req_dst) |=> busy_q[$past(wb_idx)]);

    assert_idle_no_stall_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !stall);

endmodule

bind regscb_top regscb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_src_a   (req_src_a),
    .req_dst     (req_dst),
    .req_has_dst (req_has_dst),
    .rd_data_a   (rd_data_a),
    .stall       (stall),
    .wb_en       (wb_en),
    .wb_idx      (wb_idx),
    .busy_q      (busy_q)
);

// File: tb/regscb_top_tb.sv
module regscb_top_tb;
    import regscb_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_has_dst;
    ridx_t       req_src_a, req_src_b, req_dst;
    word_t       rd_data_a, rd_data_b;
    logic        raw_hazard, waw_hazard, stall;
    logic        wb_en;
    ridx_t       wb_idx;
    word_t       wb_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    word_t ref_data [NUM_REGS];
    bit    ref_busy [NUM_REGS];

    always #10 clk = ~clk;   // 50 MHz

    regscb_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_src_a(req_src_a),
        .req_src_b(req_src_b), .req_dst(req_dst), .req_has_dst(req_has_dst),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .raw_hazard(raw_hazard),
        .waw_hazard(waw_hazard), .stall(stall), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic bit exp_busy(input ridx_t i);
        return (i != 0) && ref_busy[i] && !(wb_en && wb_idx == i);
    endfunction

    function automatic word_t exp_rd(input ridx_t s);
        if (s == 0) return '0;
        if (wb_en && wb_idx == s) return wb_data;
        return ref_data[s];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NUM_REGS; i++) begin
            ref_data[i] = '0;
            ref_busy[i] = 1'b0;
        end
    endtask

    // One cycle: drive at negedge, judge combinational outputs, update model at posedge.
    task automatic step(input string tag, input bit v, input ridx_t a, input ridx_t b,
                        input ridx_t d, input bit hd, input bit we, input ridx_t wi, input word_t wd);
        bit e_raw, e_waw, e_stall;
        @(negedge clk);
        req_valid = v; req_src_a = a; req_src_b = b; req_dst = d; req_has_dst = hd;
        wb_en = we; wb_idx = wi; wb_data = wd;
        #2;
        e_raw   = v && (exp_busy(a) || exp_busy(b));
        e_waw   = v && hd && exp_busy(d);
        e_stall = e_raw || e_waw;
        chk(tag, "raw_hazard", raw_hazard, e_raw);
        chk(tag, "waw_hazard", waw_hazard, e_waw);
        chk(tag, "stall", stall, e_stall);
        chk(tag, "rd_data_a", rd_data_a, exp_rd(a));
        chk(tag, "rd_data_b", rd_data_b, exp_rd(b));
        @(posedge clk);
        if (we && wi != 0) begin
            ref_data[wi] = wd;
            ref_busy[wi] = 1'b0;
        end
        if (v && !e_stall && hd && d != 0) ref_busy[d] = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 0; req_src_a = 0; req_src_b = 0; req_dst = 0; req_has_dst = 0;
        wb_en = 0; wb_idx = 0; wb_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        model_reset();
        do_reset();

        // Dirty some state, then reset again and sweep all entries (R1).
        step("R3", 1, 0, 0, 5, 1, 1, 7, 32'hDEAD_0007);
        step("R4", 1, 7, 0, 9, 1, 0, 0, '0);
        do_reset();
        for (int i = 0; i < NUM_REGS; i += 2)
            step("R1", 1, ridx_t'(i), ridx_t'(i + 1), ridx_t'(i), 1'b0, 1'b0, 0, '0);

        // Entry 0: write ignored, never busy (R2).
        step("R2", 1, 0, 0, 0, 1, 1, 0, 32'hFFFF_FFFF);
        step("R2", 1, 0, 0, 0, 1, 0, 0, '0);
        chk("R2", "stall_after_dst0", stall, 1'b0);

        // Issue claims r3 (R3), then RAW on both ports (R5), WAW (R6).
        step("R3", 1, 1, 2, 3, 1, 0, 0, '0);
        step("R5", 1, 3, 0, 4, 1, 0, 0, '0);
        chk("R5", "raw_seen", raw_hazard, 1'b1);
        step("R5", 1, 0, 3, 4, 1, 0, 0, '0);
        step("R6", 1, 1, 2, 3, 1, 0, 0, '0);
        chk("R6", "waw_seen", waw_hazard, 1'b1);
        step("R6", 1, 1, 2, 3, 0, 0, 0, '0);  // no destination: no WAW
        // Held request re-checked; idle drops stall (R7, R10).
        step("R7", 1, 3, 3, 6, 1, 0, 0, '0);
        step("R7", 1, 3, 3, 6, 1, 0, 0, '0);
        step("R10", 0, 3, 3, 3, 1, 0, 0, '0);
        // Write-back releases the held request in the same cycle (R8).
        step("R8", 1, 3, 3, 6, 1, 1, 3, 32'h1234_5678);
        chk("R8", "bypass_a", rd_data_a, 32'h1234_5678);
        chk("R8", "no_stall_same_cycle", stall, 1'b0);
        step("R4", 1, 3, 0, 0, 0, 0, 0, '0);
        // Set wins over clear on one register (R9): r6 busy, wb r6 and reissue r6.
        step("R9", 1, 0, 0, 6, 1, 1, 6, 32'hCAFE_0006);
        step("R9", 1, 6, 0, 0, 0, 0, 0, '0);
        chk("R9", "still_busy", raw_hazard, 1'b1);
        step("R4", 1, 6, 0, 0, 0, 1, 6, 32'h0BAD_0006);

        // Random traffic on a narrow index window to force collisions (R5/R6/R8/R9).
        for (int n = 0; n < 4000; n++) begin
            bit    v  = ($urandom % 10) < 8;
            bit    hd = ($urandom % 10) < 7;
            bit    we = ($urandom % 10) < 4;
            ridx_t a  = ridx_t'($urandom % 8);
            ridx_t b  = ridx_t'($urandom % 8);
            ridx_t d  = ridx_t'($urandom % 8);
            ridx_t wi = ridx_t'($urandom % 8);
            step("R5/R6/R8/R9 random", v, a, b, d, hd, we, wi, word_t'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule